// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software with a watchdog that runs in two chained count phases. Once enabled, a prescaled down counter runs from a first preload value. When it passes zero, the block sets a sticky interrupt flag. The counter then reloads from a second preload value and counts down again. If that second phase also expires, the block acts on its active-low timeout pin. In watchdog mode it pulls the pin low and holds it there until a hard reset. In free-running mode it toggles the pin and starts a new cycle from the first preload.

Software talks to the block over a single-cycle register bus. The bus has no wait states and reads are combinational. The preload and reload registers are write-protected: a write takes effect only as the access directly after a two-write key sequence sent to the reload offset. A lock bit in the configuration register freezes that register until the next hard reset.

Register offsets: 00h first preload, 04h second preload, 08h status, 0Ch reload/key, 10h configuration.

Configuration fields:
- bit 0: lock
- bit 1: enable
- bit 2: mode (0 = watchdog, 1 = free-running)
- bit 3: prescale select (0 = divide by 2^FAST_LOG, 1 = divide by 2^SLOW_LOG)
- bit 4: output enable
- bits 15:5: reserved, read as zero

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset, tout_no_o is 1, irq_o is 0, the configuration reads 0 and both preloads read all ones in bits PRE_W-1:0.
- R2: The preload registers (00h, 04h) keep wdata bits PRE_W-1:0 and read zero above them. A preload write is ignored unless it is the access that directly follows a write of 80h and then a write of 86h, both to offset 0Ch (key compared on wdata bits 7:0).
- R3: Any other access, read or write, between the two key writes cancels the unlock. An open unlock is used up by the single access that follows it.
- R4: With enable set, irq_o rises L*(P1+1) clock edges after the edge that writes the enable, where L is the prescale divide and P1 is the first preload.
- R5: The status bit (08h bit 0, also irq_o) stays set until a write with bit 0 set to 08h. Writing 0 to it has no effect.
- R6: An unlocked write to 0Ch with bit 8 set restarts the first phase from P1 and clears the prescaler. A stage-1 expiry that falls on the same edge is dropped.
- R7: In watchdog mode with output enable set, tout_no_o goes low L*(P2+1) edges after irq_o rises and stays low until reset.
- R8: With output enable clear, an expiry leaves tout_no_o at 1.
- R9: In free-running mode, each second-phase expiry toggles tout_no_o and restarts from P1, so irq_o sets again after each new first phase.
- R10: Configuration bit 3 selects L = 2^SLOW_LOG when set and L = 2^FAST_LOG when clear.
- R11: Once configuration bit 0 is set, configuration writes are ignored until reset. Reserved configuration bits read zero.
- R12: Clearing enable halts counting. Re-enabling starts the first phase again from P1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Sticky first-phase expiry flag |
| tout_no_o | output | 1 | Active-low timeout output |

## Verification
The bench builds the block with PRE_W=8, FAST_LOG=1 and SLOW_LOG=3, so one prescale tick takes 2 or 8 clocks and preloads of 1 to 3 give expiries within a few dozen cycles. At those values every edge of interest can be predicted exactly: the interrupt edge, the timeout edge, a reload that lands on the same edge as a stage-1 expiry, and the free-running toggles. The key-sequence cancel and consume rules, the lock and the write-1-to-clear flag are observed through register reads and the two output pins.

// File: rtl/dual_stage_wdt_pkg.sv
package dual_stage_wdt_pkg;
  localparam logic [4:0] OFS_PRE1   = 5'h00;
  localparam logic [4:0] OFS_PRE2   = 5'h04;
  localparam logic [4:0] OFS_STAT   = 5'h08;
  localparam logic [4:0] OFS_RELOAD = 5'h0C;
  localparam logic [4:0] OFS_CFG    = 5'h10;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic [1:0] {ST_ONE, ST_TWO, ST_DONE} stage_e;

  // bit4..bit0
  typedef struct packed {
    logic out_en;
    logic presc_slow;
    logic free_run;
    logic enable;
    logic lock;
  } cfg_t;
endpackage

// File: rtl/dual_stage_wdt_regs.sv
module dual_stage_wdt_regs
  import dual_stage_wdt_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [4:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             s1_done_i,
  output cfg_t             cfg_o,
  output logic [PRE_W-1:0] pre1_o,
  output logic [PRE_W-1:0] pre2_o,
  output logic             restart_o,
  output logic             irq_o
);
  localparam int PAD_W = 32 - PRE_W;

  unlock_e          ul_q, ul_d;
  cfg_t             cfg_q;
  logic [PRE_W-1:0] pre1_q, pre2_q;
  logic             irq_q;
  logic             wr, hit_reload, key1, key2, open_wr;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr         = req_i && we_i;
  assign hit_reload = addr_i == OFS_RELOAD;
  assign key1       = wr && hit_reload && (wdata_i[7:0] == KEY_FIRST);
  assign key2       = wr && hit_reload && (wdata_i[7:0] == KEY_SECOND);
  assign open_wr    = (ul_q == UL_OPEN) && wr;

  always_comb begin
    ul_d = ul_q;
    unique case (ul_q)
      UL_IDLE: if (key1) ul_d = UL_HALF;
      UL_HALF: if (req_i) ul_d = key2 ? UL_OPEN : (key1 ? UL_HALF : UL_IDLE);
      UL_OPEN: if (req_i) ul_d = UL_IDLE;
      default: ul_d = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ul_q   <= UL_IDLE;
      cfg_q  <= '0;
      pre1_q <= '1;
      pre2_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      ul_q <= ul_d;
      if (open_wr && addr_i == OFS_PRE1) pre1_q <= wdata_i[PRE_W-1:0];
      if (open_wr && addr_i == OFS_PRE2) pre2_q <= wdata_i[PRE_W-1:0];
      if (wr && addr_i == OFS_CFG && !cfg_q.lock) cfg_q <= cfg_t'(wdata_i[4:0]);
      if (s1_done_i) irq_q <= 1'b1;
      else if (wr && addr_i == OFS_STAT && wdata_i[0]) irq_q <= 1'b0;
    end
  end

  assign restart_o = open_wr && hit_reload && wdata_i[8];

  always_comb begin
    unique case (addr_i)
      OFS_PRE1: rdata_o = {{PAD_W{1'b0}}, pre1_q};
      OFS_PRE2: rdata_o = {{PAD_W{1'b0}}, pre2_q};
      OFS_STAT: rdata_o = {31'b0, irq_q};
      OFS_CFG:  rdata_o = {27'b0, cfg_q};
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign pre1_o = pre1_q;
  assign pre2_o = pre2_q;
  assign irq_o  = irq_q;

  p_preload_guard_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ul_q != UL_OPEN) |=> ($stable(pre1_q) && $stable(pre2_q)));

  p_unlock_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ul_q == UL_OPEN && $past(ul_q) != UL_OPEN) |-> ($past(ul_q) == UL_HALF));

  p_irq_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(s1_done_i));

  p_irq_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !(wr && addr_i == OFS_STAT && wdata_i[0])) |=> irq_q);

  p_cfg_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> $stable(cfg_q));
endmodule

// File: rtl/dual_stage_wdt_presc.sv
module dual_stage_wdt_presc #(
  parameter int FAST_LOG = 5,
  parameter int SLOW_LOG = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic slow_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (SLOW_LOG > FAST_LOG) ? SLOW_LOG : FAST_LOG;
  localparam logic [CW-1:0] FAST_LAST = CW'((2 ** FAST_LOG) - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'((2 ** SLOW_LOG) - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && !clear_i && (cnt_q == (slow_i ? SLOW_LAST : FAST_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!en_i || clear_i || tick_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  p_idle_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/dual_stage_wdt_count.sv
module dual_stage_wdt_count
  import dual_stage_wdt_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             free_i,
  input  logic             out_en_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre1_i,
  input  logic [PRE_W-1:0] pre2_i,
  output logic             s1_done_o,
  output logic             tout_no_o
);
  stage_e           stage_q;
  logic [PRE_W-1:0] cnt_q;
  logic             tout_q;
  logic             hold, at_zero;

  assign hold      = !en_i || restart_i;
  assign at_zero   = cnt_q == '0;
  assign s1_done_o = !hold && tick_i && stage_q == ST_ONE && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_ONE;
      cnt_q   <= '0;
      tout_q  <= 1'b1;
    end else if (hold) begin
      stage_q <= ST_ONE;
      cnt_q   <= pre1_i;
    end else if (tick_i) begin
      unique case (stage_q)
        ST_ONE: begin
          if (at_zero) begin
            cnt_q   <= pre2_i;
            stage_q <= ST_TWO;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_TWO: begin
          if (!at_zero) cnt_q <= cnt_q - 1'b1;
          else if (free_i) begin
            cnt_q   <= pre1_i;
            stage_q <= ST_ONE;
            if (out_en_i) tout_q <= ~tout_q;
          end else begin
            stage_q <= ST_DONE;
            if (out_en_i) tout_q <= 1'b0;
          end
        end
        default: stage_q <= ST_DONE;
      endcase
    end
  end

  assign tout_no_o = tout_q;

  p_tout_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tout_q && !free_i) |=> !tout_q);

  p_done_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_DONE && !hold) |=> (stage_q == ST_DONE));

  p_quiet_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> $stable(tout_q));
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
  import dual_stage_wdt_pkg::*;
#(
  parameter int PRE_W    = 20,
  parameter int FAST_LOG = 5,
  parameter int SLOW_LOG = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        tout_no_o
);
  cfg_t             cfg;
  logic [PRE_W-1:0] pre1, pre2;
  logic             restart, tick, s1_done;

  dual_stage_wdt_regs #(.PRE_W(PRE_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .s1_done_i (s1_done),
    .cfg_o     (cfg),
    .pre1_o    (pre1),
    .pre2_o    (pre2),
    .restart_o (restart),
    .irq_o     (irq_o)
  );

  dual_stage_wdt_presc #(.FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)) u_presc (
    .clk_i, .rst_ni,
    .en_i    (cfg.enable),
    .slow_i  (cfg.presc_slow),
    .clear_i (restart),
    .tick_o  (tick)
  );

  dual_stage_wdt_count #(.PRE_W(PRE_W)) u_count (
    .clk_i, .rst_ni,
    .en_i      (cfg.enable),
    .free_i    (cfg.free_run),
    .out_en_i  (cfg.out_en),
    .tick_i    (tick),
    .restart_i (restart),
    .pre1_i    (pre1),
    .pre2_i    (pre2),
    .s1_done_o (s1_done),
    .tout_no_o (tout_no_o)
  );
endmodule

// File: tb/dual_stage_wdt_tb.sv
`timescale 1ns/1ps
module dual_stage_wdt_tb;
  localparam logic [4:0] A_P1 = 5'h00, A_P2 = 5'h04, A_ST = 5'h08, A_RL = 5'h0C, A_CF = 5'h10;

  logic        clk = 0, rst_n = 0, req = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, tout_n;
  int          checks = 0, failures = 0;

  always #4 clk = ~clk;

  dual_stage_wdt #(.PRE_W(8), .FAST_LOG(1), .SLOW_LOG(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tout_no_o(tout_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    req = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    req = 0; we = 0;
    @(negedge clk); rst_n = 0;
    wait_cyc(2);
    rst_n = 1;
    wait_cyc(1);
  endtask

  task automatic unlock();
    wr(A_RL, 32'h80);
    wr(A_RL, 32'h86);
  endtask

  task automatic setup(input int p1, input int p2);
    unlock(); wr(A_P1, p1);
    unlock(); wr(A_P2, p2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 tout", {31'b0, tout_n}, 1);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_CF, d); chk("R1 cfg", d, 0);
    rd(A_P1, d); chk("R1 pre1", d, 32'hFF);
  endtask

  task automatic t_guard();
    logic [31:0] d;
    wr(A_P1, 5);
    rd(A_P1, d); chk("R2 locked preload write ignored", d, 32'hFF);
    unlock(); wr(A_P1, 32'hFFF0_0003);
    rd(A_P1, d); chk("R2 preload upper bits zero", d, 3);
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    wr(A_RL, 32'h80); rd(A_ST, d); wr(A_RL, 32'h86); wr(A_P1, 9);
    rd(A_P1, d); chk("R3 interrupted key", d, 3);
    unlock(); wr(A_P2, 2); wr(A_P2, 6);
    rd(A_P2, d); chk("R3 unlock consumed", d, 2);
  endtask

  task automatic t_watchdog();
    wr(A_CF, 32'h12);            // enable + out_en, L=2, P1=3, P2=2
    wait_cyc(7); chk("R4 irq before", {31'b0, irq}, 0);
    wait_cyc(1); chk("R4 irq at 8", {31'b0, irq}, 1);
    wr(A_ST, 0); chk("R5 write 0 keeps flag", {31'b0, irq}, 1);
    wr(A_ST, 1); chk("R5 write 1 clears", {31'b0, irq}, 0);
    wait_cyc(3); chk("R7 tout before", {31'b0, tout_n}, 1);
    wait_cyc(1); chk("R7 tout low", {31'b0, tout_n}, 0);
    wait_cyc(20); chk("R7 tout held", {31'b0, tout_n}, 0);
  endtask

  task automatic t_reload();
    do_reset(); setup(3, 2);
    wr(A_CF, 32'h12);
    wait_cyc(5); unlock(); wr(A_RL, 32'h100);   // lands on expiry edge
    chk("R6 expiry dropped", {31'b0, irq}, 0);
    wait_cyc(7); chk("R6 irq before", {31'b0, irq}, 0);
    wait_cyc(1); chk("R6 irq after restart", {31'b0, irq}, 1);
  endtask

  task automatic t_out_dis();
    do_reset(); setup(1, 1);
    wr(A_CF, 32'h02);
    wait_cyc(20);
    chk("R8 irq", {31'b0, irq}, 1);
    chk("R8 tout idle", {31'b0, tout_n}, 1);
  endtask

  task automatic t_free();
    do_reset(); setup(1, 1);
    wr(A_CF, 32'h16);
    wait_cyc(4); chk("R9 first irq", {31'b0, irq}, 1);
    wr(A_ST, 1);
    wait_cyc(2); chk("R9 tout before", {31'b0, tout_n}, 1);
    wait_cyc(1); chk("R9 tout toggled low", {31'b0, tout_n}, 0);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    wait_cyc(4); chk("R9 irq again", {31'b0, irq}, 1);
    wait_cyc(4); chk("R9 tout toggled high", {31'b0, tout_n}, 1);
  endtask

  task automatic t_presc();
    do_reset(); setup(1, 1);
    wr(A_CF, 32'h1A);
    wait_cyc(15); chk("R10 slow irq before", {31'b0, irq}, 0);
    wait_cyc(1);  chk("R10 slow irq at 16", {31'b0, irq}, 1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset(); setup(1, 1);
    wr(A_CF, 32'hFFE0);
    rd(A_CF, d); chk("R11 reserved zero", d, 0);
    wr(A_CF, 32'h01);
    wr(A_CF, 32'h12);
    rd(A_CF, d); chk("R11 locked cfg", d, 1);
    wr(A_CF, 32'h00);
    rd(A_CF, d); chk("R11 lock sticky", d, 1);
    wait_cyc(10); chk("R11 enable ignored", {31'b0, irq}, 0);
  endtask

  task automatic t_disable();
    do_reset(); setup(3, 2);
    wr(A_CF, 32'h12);
    wait_cyc(5);
    wr(A_CF, 32'h10);
    wr(A_CF, 32'h12);
    wait_cyc(7); chk("R12 irq before", {31'b0, irq}, 0);
    wait_cyc(1); chk("R12 restart from P1", {31'b0, irq}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    t_reset();
    t_guard();
    t_cancel();
    t_watchdog();
    t_reload();
    t_out_dis();
    t_free();
    t_presc();
    t_lock();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule